// File: doc/BRIEF.md
# Context Sequencer for a Double-Buffered Systolic Array

This block sequences a whole computation on a systolic array whose results are double-buffered. Each processing element holds an accumulator and a reserve register. When a host start pulse arrives, the block requests the first preload read. That read is shifted into the reserve registers and then moved into the accumulators. Once the scan unit reports the first preload ready, the block starts the feeder FSM and asks for two more preload reads, so that every register level holds data.

After that, the block alternates between compute and scan phases:
- While a context computes, the block enables the context-switch logic.
- When the switch counter signals the end of a context and the switch has travelled across the array, the block triggers a scan. The scan extracts the finished results and inserts the next preloads while the array computes the next context.

A context can end before its scan has finished. In that case the block stalls the array in one of two ways:
- **Hard stall.** The pipeline gate is dropped.
- **Soft stall.** The FIFOs stop popping and drive zeros while the pipeline keeps moving. The block uses this when a shift or a context switch is still in flight.

After the configured number of contexts has been scanned out, the block waits for the feeder FSM to report done, resets it and returns to idle.

Top module: `ctx_sequencer`

## Requirements
- R1: After reset the block is idle. All outputs are low, and stay low until a host start arrives.
- R2: In idle, host_start raises preload_req in the same cycle. The block then waits for scan_first_rdy.
- R3: scan_first_rdy starts the feed phase on the next cycle:
  - feed_start is high for exactly one cycle.
  - preload_req is high in that cycle and in the following cycle (two extra reads).
  - The block then computes.
- R4: While computing, and while waiting for switch propagation, switch_en and pipe_gate are high. A ctx_done while computing moves the block to wait for propagation. switch_prop_done then raises scan_trigger for one cycle and the scan phase begins.
- R5: During a scan, ctx_done with scan_done low and neither shift_active nor switch_active high is a hard stall. pipe_gate drops in that same cycle and stays low up to and including the cycle in which scan_done is seen. It is high again from the next cycle.
- R6: During a scan, ctx_done with scan_done low and shift_active or switch_active high is a soft stall.
  - soft_stall rises in that same cycle and pipe_gate stays high.
  - The soft stall holds until scan_done, and pipe_gate stays high throughout it.
  - If both activity inputs are low in a cycle before scan_done, the soft stall becomes a hard stall from the next cycle.
- R7: If ctx_done and scan_done coincide during a scan, no stall of either kind occurs. The block goes straight to waiting for switch propagation, and switch_en is high on the next cycle.
- R8: When scan_done ends a stall, the block waits for switch propagation: switch_en is high and pipe_gate is high from the next cycle.
- R9: A context is counted on each accepted ctx_done. When a scan completes with no pending context and the count has reached cfg_num_ctx (a value of 0 counts as 1), the block enters a finish phase:
  - switch_en is low and pipe_gate is high.
  - feed_done raises feed_rst in that cycle and the block returns to idle.
  - Otherwise a completed scan returns the block to computing.
- R10: host_start outside idle has no effect: no preload_req is raised by it and the sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_num_ctx | input | CTX_W | Number of contexts in the computation (0 treated as 1) |
| host_start | input | 1 | Start pulse from the host |
| scan_first_rdy | input | 1 | First preload has reached the accumulators |
| scan_done | input | 1 | Scan unit finished extraction and preload fetch |
| ctx_done | input | 1 | Switch counter reports the end of a context |
| switch_prop_done | input | 1 | Context switch has propagated through the array |
| shift_active | input | 1 | A shift through the array is in flight |
| switch_active | input | 1 | A context switch is in flight |
| feed_done | input | 1 | Feeder FSM has finished all reads |
| preload_req | output | 1 | Request one preload read |
| scan_trigger | output | 1 | Start an extraction and preload scan |
| feed_start | output | 1 | Start the feeder FSM |
| feed_rst | output | 1 | Reset the feeder FSM |
| switch_en | output | 1 | Allow context-switch sequence generation |
| pipe_gate | output | 1 | Pipeline gate; low means hard stall |
| soft_stall | output | 1 | FIFOs hold and output zeros |

## Verification
The delicate coincidence is a context end and scan completion arriving in the same cycle during a scan. That cycle must produce neither stall and must move straight to switch propagation; one cycle either way would freeze the array or lose a context. A second coincidence is an activity input falling in the same cycle as scan_done while a soft stall holds, where the release must win over the escalation to a hard stall. The bench drives random scan, switch, activity and feeder inputs so that these cycles happen many times. It compares every output in every cycle against a bench model of the requirements, and tags each comparison with the situation it covers.

// File: rtl/ctx_seq_pkg.sv
package ctx_seq_pkg;

  typedef enum logic [2:0] {
    M_IDLE,
    M_FIRST_PRELOAD,
    M_START_FEED,
    M_COMPUTE,
    M_WAIT_SWITCH,
    M_SCAN,
    M_FINISH
  } main_st_t;

  typedef enum logic [1:0] {
    S_RUN,
    S_HARD,
    S_SOFT
  } stall_st_t;

  // States in which the array pipeline is allowed to advance
  function automatic logic pipe_live(input main_st_t s);
    return (s == M_COMPUTE) || (s == M_WAIT_SWITCH) || (s == M_SCAN) || (s == M_FINISH);
  endfunction

endpackage

// File: rtl/ctx_counter.sv
module ctx_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_num,
  input  logic          clr,
  input  logic          inc,
  output logic          at_target
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q;

  function automatic logic [CW-1:0] eff_target(input logic [CW-1:0] c);
    return (c == '0) ? ONE : c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + ONE;
  end

  assign at_target = (cnt_q >= eff_target(cfg_num));

  // R9: a context end is only accepted while contexts remain
  a_r9_no_extra_ctx: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> !at_target);

endmodule

// File: rtl/ctx_stall_fsm.sv
module ctx_stall_fsm
  import ctx_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_scan,
  input  logic pending,
  input  logic ctx_done,
  input  logic scan_done,
  input  logic shift_active,
  input  logic switch_active,
  output logic hard_hit,
  output logic soft_hit,
  output logic stall_hard,
  output logic stall_soft
);
  stall_st_t st_q, st_d;
  logic early_end, in_motion;

  assign in_motion = shift_active | switch_active;
  assign early_end = in_scan & ctx_done & ~scan_done & ~pending & (st_q == S_RUN);
  assign hard_hit  = early_end & ~in_motion;
  assign soft_hit  = early_end &  in_motion;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_RUN:  if (hard_hit) st_d = S_HARD;
              else if (soft_hit) st_d = S_SOFT;
      S_SOFT: if (scan_done) st_d = S_RUN;
              else if (!in_motion) st_d = S_HARD;
      S_HARD: if (scan_done) st_d = S_RUN;
      default: st_d = S_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_RUN;
    else        st_q <= st_d;
  end

  assign stall_hard = (st_q == S_HARD);
  assign stall_soft = (st_q == S_SOFT);

  // R5: a hard stall is only left through scan completion
  a_r5_hard_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_hard && !scan_done) |=> stall_hard);

  // R6: soft stall escalates once the array is quiet
  a_r6_soft_escalates: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_soft && !scan_done && !shift_active && !switch_active) |=> stall_hard);

endmodule

// File: rtl/ctx_main_fsm.sv
module ctx_main_fsm
  import ctx_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     host_start,
  input  logic     first_rdy,
  input  logic     scan_done,
  input  logic     ctx_done,
  input  logic     switch_prop_done,
  input  logic     feed_done,
  input  logic     at_target,
  output main_st_t state,
  output logic     pending,
  output logic     cnt_clr,
  output logic     cnt_inc,
  output logic     preload_req,
  output logic     feed_start,
  output logic     feed_rst,
  output logic     switch_en,
  output logic     scan_trigger
);
  main_st_t st_q, st_d;
  logic pend_q, pend_d;
  logic ph_q, ph_d;

  always_comb begin
    st_d    = st_q;
    pend_d  = pend_q;
    ph_d    = ph_q;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    unique case (st_q)
      M_IDLE: if (host_start) begin
        st_d    = M_FIRST_PRELOAD;
        cnt_clr = 1'b1;
        pend_d  = 1'b0;
      end
      M_FIRST_PRELOAD: if (first_rdy) begin
        st_d = M_START_FEED;
        ph_d = 1'b0;
      end
      M_START_FEED: begin
        ph_d = 1'b1;
        if (ph_q) st_d = M_COMPUTE;
      end
      M_COMPUTE: if (ctx_done) begin
        cnt_inc = 1'b1;
        st_d    = M_WAIT_SWITCH;
      end
      M_WAIT_SWITCH: if (switch_prop_done) st_d = M_SCAN;
      M_SCAN: begin
        if (scan_done) begin
          pend_d = 1'b0;
          if (pend_q || ctx_done) begin
            st_d    = M_WAIT_SWITCH;
            cnt_inc = ctx_done & ~pend_q;
          end else if (at_target) begin
            st_d = M_FINISH;
          end else begin
            st_d = M_COMPUTE;
          end
        end else if (ctx_done && !pend_q) begin
          cnt_inc = 1'b1;
          pend_d  = 1'b1;
        end
      end
      M_FINISH: if (feed_done) st_d = M_IDLE;
      default: st_d = M_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= M_IDLE;
      pend_q <= 1'b0;
      ph_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      ph_q   <= ph_d;
    end
  end

  assign state        = st_q;
  assign pending      = pend_q;
  assign preload_req  = ((st_q == M_IDLE) && host_start) || (st_q == M_START_FEED);
  assign feed_start   = (st_q == M_START_FEED) && !ph_q;
  assign feed_rst     = (st_q == M_FINISH) && feed_done;
  assign switch_en    = (st_q == M_COMPUTE) || (st_q == M_WAIT_SWITCH);
  assign scan_trigger = (st_q == M_WAIT_SWITCH) && switch_prop_done;

  // R3: the feeder start is followed by the second extra preload read
  a_r3_second_read: assert property (@(posedge clk) disable iff (!rst_n)
    feed_start |=> (preload_req && !feed_start));

  // R4: a scan trigger leaves the switch-enabled phases
  a_r4_trigger_leaves: assert property (@(posedge clk) disable iff (!rst_n)
    scan_trigger |=> !switch_en);

  // R9: after the feeder reset the block is back in idle
  a_r9_reset_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    feed_rst |=> (state == M_IDLE));

endmodule

// File: rtl/ctx_sequencer.sv
module ctx_sequencer
  import ctx_seq_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CTX_W-1:0] cfg_num_ctx,
  input  logic             host_start,
  input  logic             scan_first_rdy,
  input  logic             scan_done,
  input  logic             ctx_done,
  input  logic             switch_prop_done,
  input  logic             shift_active,
  input  logic             switch_active,
  input  logic             feed_done,
  output logic             preload_req,
  output logic             scan_trigger,
  output logic             feed_start,
  output logic             feed_rst,
  output logic             switch_en,
  output logic             pipe_gate,
  output logic             soft_stall
);
  main_st_t state;
  logic pending, cnt_clr, cnt_inc, at_target;
  logic hard_hit, soft_hit, stall_hard, stall_soft;

  ctx_main_fsm u_main (
    .clk(clk), .rst_n(rst_n),
    .host_start(host_start), .first_rdy(scan_first_rdy),
    .scan_done(scan_done), .ctx_done(ctx_done),
    .switch_prop_done(switch_prop_done), .feed_done(feed_done),
    .at_target(at_target),
    .state(state), .pending(pending),
    .cnt_clr(cnt_clr), .cnt_inc(cnt_inc),
    .preload_req(preload_req), .feed_start(feed_start),
    .feed_rst(feed_rst), .switch_en(switch_en),
    .scan_trigger(scan_trigger)
  );

  ctx_stall_fsm u_stall (
    .clk(clk), .rst_n(rst_n),
    .in_scan(state == M_SCAN), .pending(pending),
    .ctx_done(ctx_done), .scan_done(scan_done),
    .shift_active(shift_active), .switch_active(switch_active),
    .hard_hit(hard_hit), .soft_hit(soft_hit),
    .stall_hard(stall_hard), .stall_soft(stall_soft)
  );

  ctx_counter #(.CW(CTX_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .cfg_num(cfg_num_ctx),
    .clr(cnt_clr), .inc(cnt_inc),
    .at_target(at_target)
  );

  assign pipe_gate  = pipe_live(state) && !stall_hard && !hard_hit;
  assign soft_stall = stall_soft || soft_hit;

  // R5: the gate stays low while the hard stall waits for the scan
  a_r5_gate_held: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_hard && !scan_done) |=> !pipe_gate);

  // R6: a soft stall never closes the gate
  a_r6_soft_keeps_gate: assert property (@(posedge clk) disable iff (!rst_n)
    soft_stall |-> pipe_gate);

  // R7: coincident context end and scan completion proceed to the switch
  a_r7_coincide: assert property (@(posedge clk) disable iff (!rst_n)
    (state == M_SCAN && ctx_done && scan_done) |=> (switch_en && pipe_gate));

endmodule

// File: tb/ctx_sequencer_tb.sv
module ctx_sequencer_tb;
  localparam int CW = 8;
  localparam int N_CYC = 30000;
  localparam int I = 0, FP = 1, SF = 2, CM = 3, WS = 4, SC = 5, FN = 6;
  localparam int RUNS = 0, HARD = 1, SOFT = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic [CW-1:0] cfg;
  logic hs, fr, sd, cd, spd, sh, sw, fd;
  logic preload_req, scan_trigger, feed_start, feed_rst, switch_en, pipe_gate, soft_stall;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  int m_st = I, m_ph = 0, m_cnt = 0, m_pend = 0, m_stl = RUNS;

  ctx_sequencer #(.CTX_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_num_ctx(cfg),
    .host_start(hs), .scan_first_rdy(fr), .scan_done(sd), .ctx_done(cd),
    .switch_prop_done(spd), .shift_active(sh), .switch_active(sw), .feed_done(fd),
    .preload_req(preload_req), .scan_trigger(scan_trigger), .feed_start(feed_start),
    .feed_rst(feed_rst), .switch_en(switch_en), .pipe_gate(pipe_gate), .soft_stall(soft_stall)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int tgt();
    return (cfg == 0) ? 1 : int'(cfg);
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg = 8'd2;
    {hs, fr, sd, cd, spd, sh, sw, fd} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: idle after reset, every output low
    chk("R1 preload_req", preload_req, 1'b0);
    chk("R1 pipe_gate", pipe_gate, 1'b0);
    chk("R1 switch_en", switch_en, 1'b0);
    chk("R1 soft_stall", soft_stall, 1'b0);
    chk("R1 feed_start", feed_start, 1'b0);
    chk("R1 scan_trigger", scan_trigger, 1'b0);
    chk("R1 feed_rst", feed_rst, 1'b0);

    void'($urandom(32'd4711));
    for (int c = 0; c < N_CYC; c++) begin
      @(negedge clk);
      if (m_st == I && ($urandom % 4) == 0) cfg = CW'($urandom % 4);
      hs  = ($urandom % 8) == 0;
      fr  = ($urandom % 4) == 0;
      sd  = ($urandom % 5) == 0;
      spd = ($urandom % 3) == 0;
      sh  = ($urandom % 3) == 0;
      sw  = ($urandom % 3) == 0;
      fd  = ($urandom % 4) == 0;
      cd  = ($urandom % 5) == 0;
      if (m_st == SC && (m_pend != 0 || m_cnt >= tgt())) cd = 1'b0;
      #1;
      begin
        bit hit, e_pre, e_fs, e_sen, e_trg, e_gate, e_soft, e_frst;
        string tg;
        hit    = (m_st == SC) && cd && !sd && (m_pend == 0);
        e_pre  = (m_st == I && hs) || (m_st == SF);
        e_fs   = (m_st == SF) && (m_ph == 0);
        e_sen  = (m_st == CM) || (m_st == WS);
        e_trg  = (m_st == WS) && spd;
        e_gate = (m_st == CM || m_st == WS || m_st == SC || m_st == FN)
                 && (m_stl != HARD) && !(hit && !sh && !sw);
        e_soft = (m_stl == SOFT) || (hit && (sh || sw));
        e_frst = (m_st == FN) && fd;
        tg = "";
        if (m_st == SC && cd && sd) tg = "R7";
        else if (m_st != I && hs) tg = "R10";
        else if (m_st == SC && sd && m_pend != 0) tg = "R8";
        chk((tg != "") ? {tg, " preload_req"} : "R2 preload_req", preload_req, e_pre);
        chk((tg != "") ? {tg, " feed_start"} : "R3 feed_start", feed_start, e_fs);
        chk((tg != "") ? {tg, " switch_en"} : "R4 switch_en", switch_en, e_sen);
        chk((tg != "") ? {tg, " scan_trigger"} : "R4 scan_trigger", scan_trigger, e_trg);
        chk((tg != "") ? {tg, " pipe_gate"} : "R5 pipe_gate", pipe_gate, e_gate);
        chk((tg != "") ? {tg, " soft_stall"} : "R6 soft_stall", soft_stall, e_soft);
        chk((tg != "") ? {tg, " feed_rst"} : "R9 feed_rst", feed_rst, e_frst);
        // model update for the coming edge: stall part first, from current state
        case (m_stl)
          RUNS: if (hit) m_stl = (sh || sw) ? SOFT : HARD;
          SOFT: if (sd) m_stl = RUNS; else if (!sh && !sw) m_stl = HARD;
          default: if (sd) m_stl = RUNS;
        endcase
        case (m_st)
          I:  if (hs) begin m_st = FP; m_cnt = 0; m_pend = 0; end
          FP: if (fr) begin m_st = SF; m_ph = 0; end
          SF: if (m_ph == 1) m_st = CM; else m_ph = 1;
          CM: if (cd) begin m_cnt++; m_st = WS; end
          WS: if (spd) m_st = SC;
          SC: if (sd) begin
                if (m_pend != 0) m_st = WS;
                else if (cd) begin m_cnt++; m_st = WS; end
                else m_st = (m_cnt >= tgt()) ? FN : CM;
                m_pend = 0;
              end else if (cd && m_pend == 0) begin
                m_cnt++; m_pend = 1;
              end
          default: if (fd) m_st = I;
        endcase
      end
    end
    finished = 1;
    summary();
  end
endmodule